// File: doc/BRIEF.md
# Programmable Interrupt Request Register

This block holds a set of seven software-raised interrupt requests, one per priority level from 1 to 7. Software writes the request bits into the upper part of a 16-bit register. The block encodes the highest pending level and shows it in the same register. The level appears twice: once in the middle of the low byte and once at its bottom. The same level is also driven on a separate 3-bit output, which the processor compares against its current priority.

The register is reached through a plain read/write port that handles both word and byte access. A word access reads or writes all 16 bits. A byte access picks the low byte or the high byte with an odd-address select. The read port is combinational from the stored bits, so the encoded fields always match the stored request bits. A read in the cycle after a write already shows the new level.

Top module: `pirq_reg`

## Requirements
- R1: After reset the register reads as 0x0000 and `level_o` is 0.
- R2: A word write (`acc_byte`=0) stores only `wr_data[15:9]` as request bits. Whatever is written to bits 8:0 has no effect on the value read back.
- R3: The encoded level is the index of the highest set request bit minus 8. Bit 9 alone gives 1, and any value with bit 15 set gives 7. Lower request bits do not change the result.
- R4: In a word read, bits 7:5 and bits 3:1 both carry the encoded level, and bits 8, 4 and 0 read as 0.
- R5: When no request bit is set, both level fields and `level_o` are 0.
- R6: A word read returns all 16 bits. A byte read (`acc_byte`=1) puts the low byte (`acc_odd`=0) or the high byte (`acc_odd`=1) on `rd_data[7:0]`, with `rd_data[15:8]` = 0.
- R7: A byte write at the odd address stores `wr_data[7:1]` as request bits 15:9. A byte write at the even address leaves the register unchanged.
- R8: `level_o` always equals the encoded level. In the cycle after a write, both `rd_data` and `level_o` show the value just written.
- R9: With `wr_en` low, the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_odd | input | 1 | Byte lane select for byte access (1 = high byte) |
| wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_data | output | 16 | Combinational read data |
| level_o | output | 3 | Highest pending request level, 0 when none |

## Verification
A write and a read can fall in the same cycle. This is provoked on every bench operation, because each write is driven while the read lines select some view of the register. Before the clock edge, the bench judges `rd_data` against the old stored value. After the edge, it judges `rd_data` and `level_o` against the new value. Random request patterns with one, several or no bits set are mixed with odd and even byte writes, so the encoder and the lane select are checked in the same cycles as the updates.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int DATA_W   = 16;
    localparam int REQ_BITS = 7;
    localparam int REQ_LSB  = 9;
    localparam int LVL_W    = 3;
    localparam int HI_LSB   = 5;
    localparam int LO_LSB   = 1;
    localparam int BYTE_W   = 8;

    typedef logic [REQ_BITS-1:0] req_t;
    typedef logic [LVL_W-1:0]    lvl_t;

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_WORD = 2'd1,
        WR_HIGH = 2'd2,
        WR_LOW  = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/pirq_store.sv
module pirq_store
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    output req_t              req_q
);
    localparam int HB_LSB = REQ_LSB - BYTE_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            unique case (kind)
                WR_WORD: req_q <= wr_data[REQ_LSB +: REQ_BITS];
                WR_HIGH: req_q <= wr_data[HB_LSB +: REQ_BITS];
                WR_LOW:  req_q <= req_q;
                WR_NONE: req_q <= req_q;
                default: req_q <= req_q;
            endcase
        end
    end
endmodule

// File: rtl/pirq_encoder.sv
module pirq_encoder
    import pirq_pkg::*;
(
    input  req_t req,
    output lvl_t lvl
);
    lvl_t stage [REQ_BITS+1];

    assign stage[0] = '0;

    generate
        for (genvar k = 0; k < REQ_BITS; k++) begin : g_prio
            assign stage[k+1] = req[k] ? lvl_t'(k + 1) : stage[k];
        end
    endgenerate

    assign lvl = stage[REQ_BITS];
endmodule

// File: rtl/pirq_readmux.sv
module pirq_readmux
    import pirq_pkg::*;
(
    input  req_t              req,
    input  lvl_t              lvl,
    input  logic              acc_byte,
    input  logic              acc_odd,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_view;

    always_comb begin
        word_view = '0;
        word_view[REQ_LSB +: REQ_BITS] = req;
        word_view[HI_LSB  +: LVL_W]    = lvl;
        word_view[LO_LSB  +: LVL_W]    = lvl;
    end

    always_comb begin
        if (!acc_byte)
            rd_data = word_view;
        else if (acc_odd)
            rd_data = {{(DATA_W-BYTE_W){1'b0}}, word_view[DATA_W-1 -: BYTE_W]};
        else
            rd_data = {{(DATA_W-BYTE_W){1'b0}}, word_view[BYTE_W-1:0]};
    end
endmodule

// File: rtl/pirq_reg.sv
module pirq_reg
    import pirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_byte,
    input  logic              acc_odd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level_o
);
    wr_kind_e kind;
    req_t     req_q;
    lvl_t     lvl;

    always_comb begin
        if (!wr_en)        kind = WR_NONE;
        else if (!acc_byte) kind = WR_WORD;
        else if (acc_odd)  kind = WR_HIGH;
        else               kind = WR_LOW;
    end

    pirq_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .wr_data (wr_data),
        .req_q   (req_q)
    );

    pirq_encoder u_enc (
        .req (req_q),
        .lvl (lvl)
    );

    pirq_readmux u_mux (
        .req      (req_q),
        .lvl      (lvl),
        .acc_byte (acc_byte),
        .acc_odd  (acc_odd),
        .rd_data  (rd_data)
    );

    assign level_o = lvl;
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
    import pirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_byte,
    input logic              acc_odd,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [LVL_W-1:0]  level_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (level_o == '0));

    // R2
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_byte) ##1 !acc_byte |->
            rd_data[DATA_W-1:REQ_LSB] == $past(wr_data[DATA_W-1:REQ_LSB]));

    // R3
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_byte && rd_data[DATA_W-1]) |-> (level_o == 3'd7));

    // R4
    dual_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_byte |-> (rd_data[HI_LSB +: LVL_W] == level_o &&
                       rd_data[LO_LSB +: LVL_W] == level_o &&
                       !rd_data[8] && !rd_data[4] && !rd_data[0]));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_byte && rd_data[DATA_W-1:REQ_LSB] == '0) |-> (level_o == '0));

    // R6
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_byte |-> (rd_data[DATA_W-1:BYTE_W] == '0));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(level_o));
endmodule

bind pirq_reg pirq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_byte (acc_byte),
    .acc_odd  (acc_odd),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .level_o  (level_o)
);

// File: tb/sim_pirq_reg.sv
module sim_pirq_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_byte = 1'b0;
    logic        acc_odd = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [2:0]  level_o;

    int checks = 0;
    int failures = 0;
    logic [6:0] model = '0;
    int unsigned seed_val;

    always #4 clk = ~clk;

    pirq_reg u0 (
        .clk(clk), .rst_n(rst_n), .acc_byte(acc_byte), .acc_odd(acc_odd),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .level_o(level_o)
    );

    function automatic logic [2:0] enc(input logic [6:0] r);
        logic [2:0] v = 3'd0;
        for (int k = 0; k < 7; k++) if (r[k]) v = 3'(k + 1);
        return v;
    endfunction

    function automatic logic [15:0] view(input logic [6:0] r, input logic b, input logic o);
        logic [15:0] w = {r, 1'b0, enc(r), 1'b0, enc(r), 1'b0};
        if (!b) return w;
        return o ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    // one operation: same-cycle old value, then post-edge new value
    task automatic op(input logic w, input logic b, input logic o, input logic [15:0] d);
        @(negedge clk);
        wr_en = w; acc_byte = b; acc_odd = o; wr_data = d;
        #1;
        check("R6 same-cycle read", rd_data, view(model, b, o));
        @(posedge clk);
        if (w && !b) model = d[15:9];
        else if (w && b && o) model = d[7:1];
        #1;
        check("R8 next-cycle read", rd_data, view(model, b, o));
        check("R8 level", {13'd0, level_o}, {13'd0, enc(model)});
        wr_en = 1'b0;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        seed_val = 32'd17;
        void'($urandom(seed_val));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset word", rd_data, 16'h0000);
        check("R1 reset level", {13'd0, level_o}, 16'd0);

        // R2: low bits dropped
        op(1'b1, 1'b0, 1'b0, 16'h01FF);
        check("R2 low bits ignored", rd_data, 16'h0000);
        // R3: bit 9 alone -> 1
        op(1'b1, 1'b0, 1'b0, 16'h0200);
        check("R3 bit9 level", rd_data, 16'h0222);
        // R3/R4: bit 15 with others -> 7
        op(1'b1, 1'b0, 1'b0, 16'hAA00);
        check("R3 bit15 level", {13'd0, level_o}, 16'd7);
        check("R4 dual fields", rd_data, 16'hAAEE);
        // R6 byte reads
        op(1'b0, 1'b1, 1'b0, 16'h0000);
        check("R6 low byte", rd_data, 16'h00EE);
        op(1'b0, 1'b1, 1'b1, 16'h0000);
        check("R6 high byte", rd_data, 16'h00AA);
        // R7: even byte write ignored, odd byte write applied
        op(1'b1, 1'b1, 1'b0, 16'h00FF);
        op(1'b0, 1'b0, 1'b0, 16'h0000);
        check("R7 even byte write ignored", rd_data, 16'hAAEE);
        op(1'b1, 1'b1, 1'b1, 16'h0010);
        op(1'b0, 1'b0, 1'b0, 16'h0000);
        check("R7 odd byte write", rd_data, 16'h1088);
        // R9: no write holds
        op(1'b0, 1'b0, 1'b0, 16'hFFFF);
        check("R9 hold", rd_data, 16'h1088);
        // R5: clear
        op(1'b1, 1'b0, 1'b0, 16'h0000);
        check("R5 empty", rd_data, 16'h0000);
        check("R5 level zero", {13'd0, level_o}, 16'd0);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] d = 16'($urandom());
            if (i % 5 == 0) d = 16'h0200 << ($urandom() % 7);
            op(1'($urandom()), 1'($urandom()), 1'($urandom()), d);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule